// File: doc/BRIEF.md
# LIN Bus Sleep and Wake-Up Supervisor

This block sits next to a LIN frame engine and looks after the bus power state and the error gate. Software controls it through a small write port. One write target holds the control bits: the sleep level, a wake-up request, an error reset and a master frame request. The other target clears status flags when a 1 is written to them. The block watches the received bus line for inactivity and for wake-up pulses from other nodes. On request it drives its own wake-up pulse onto the transmit line.

A completed wake-up pulse is reported differently in each role. A master sets DONE. A slave reports nothing, but starts a response window. If the master stays silent for the whole window, the slave sets ERROR and a timeout code. Errors reported by the frame engine are also latched. While ERROR is set, wake-up and frame requests are refused. All millisecond and second intervals count a 1 ms tick that a prescaler derives from the system clock, so every interval is a parameter.

Top module: `lin_power_supervisor`

## Requirements
- R1: After reset, lin_tx_o is 1 (recessive), sleep_o is 0, status_o and err_code_o are 0, and irq_o, frame_go_o and frame_abort_o are 0.
- R2: A control write (wr_sel_i=0) loads sleep_o from wr_data_i[0]. sleep_o changes only on a control write, and an idle timeout never sets it.
- R3: While sleep_o is 0, if lin_rx_i has no edge for IDLE_MS milliseconds, the idle flag status_o[3] is set. Any edge on lin_rx_i restarts the interval. While sleep_o is 1 the interval is held at zero.
- R4: A control write with wr_data_i[1]=1, made while ERROR is clear, drives lin_tx_o low for exactly WAKE_TX_CYC clock cycles, starting at the clock edge that takes the write.
- R5: With master_mode_i=1, the end of the node's own wake-up pulse sets DONE (status_o[0]), and irq_o goes high.
- R6: With master_mode_i=0, the end of the node's own wake-up pulse does not set DONE. If no falling edge appears on lin_rx_i within RESP_MS milliseconds, ERROR (status_o[2]) and err_code_o[0] are set. A falling edge inside the window cancels the timeout.
- R7: A low level on lin_rx_i that lasts at least WAKE_RX_MIN clock cycles, while the node is not transmitting, sets WAKEUP (status_o[1]) and DONE. A shorter low level sets neither.
- R8: A high cycle on frame_err_i sets ERROR and err_code_o[1], and pulses frame_abort_o for one cycle on the next clock edge.
- R9: A control write with wr_data_i[2]=1 clears ERROR and both bits of err_code_o.
- R10: While ERROR is set, wake-up requests and frame requests (wr_data_i[3]) are ignored. With ERROR clear and master_mode_i=1, a frame request pulses frame_go_o for one cycle at the next edge. In slave mode a frame request is ignored.
- R11: A status write (wr_sel_i=1) clears DONE with bit 0, WAKEUP with bit 1 and the idle flag with bit 3. Bit 2 has no effect, so ERROR clears only through R9. irq_o is high exactly when any of the four status flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 1 | Write target: 0 = control, 1 = status clear |
| wr_data_i | input | 4 | Write data: control bits or clear mask |
| master_mode_i | input | 1 | 1 = master role, 0 = slave role |
| frame_err_i | input | 1 | Error pulse from the frame engine |
| lin_rx_i | input | 1 | Received bus level, already synchronised |
| lin_tx_o | output | 1 | Transmitted bus level (0 = dominant) |
| sleep_o | output | 1 | Sleep control bit |
| status_o | output | 4 | {idle, ERROR, WAKEUP, DONE} |
| err_code_o | output | 2 | {frame error, response timeout} |
| irq_o | output | 1 | Interrupt request |
| frame_go_o | output | 1 | One-cycle grant to start a master frame |
| frame_abort_o | output | 1 | One-cycle request to drop the current frame |

## Verification
The assertions assume that master_mode_i does not change while a slave response window is open, and that lin_rx_i arrives already synchronised to clk. They also assume that the node's own transmit level is visible on lin_rx_i, as on a real wired-AND bus. The bench models the bus as the AND of lin_tx_o and its own pull-down. It changes the role only between test phases and drives every input at the falling clock edge. Because of this, the timeout rule and the transmit gating checked by the assertions are never broken by the stimulus itself.

// File: rtl/lps_pkg.sv
package lps_pkg;
  // control write bit positions
  localparam int CTL_SLEEP  = 0;
  localparam int CTL_WAKE   = 1;
  localparam int CTL_RSTERR = 2;
  localparam int CTL_FRAME  = 3;
  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_WAKE = 1;
  localparam int ST_ERR  = 2;
  localparam int ST_IDLE = 3;
  // error code bit positions
  localparam int EC_TOUT  = 0;
  localparam int EC_FRAME = 1;
  localparam int REG_W = 4;
  localparam int EC_W  = 2;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} wr_sel_e;
endpackage

// File: rtl/lps_ms_tick.sv
module lps_ms_tick #(
  parameter int CLK_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_PER_MS - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == LAST);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r3_tick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/lps_ms_timer.sv
module lps_ms_timer #(
  parameter int LIMIT = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clear_i,
  output logic expire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d    = cnt_q;
    expire_o = 1'b0;
    if (clear_i) begin
      cnt_d = '0;
    end else if (tick_i && (cnt_q < TOP)) begin
      cnt_d    = cnt_q + 1'b1;
      expire_o = (cnt_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r3_timer_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP);
  a_r6_expire_once: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);
endmodule

// File: rtl/lps_wake_tx.sv
module lps_wake_tx #(
  parameter int LEN = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic tx_o
);
  localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic          busy_q, busy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    done_o = busy_q && (cnt_q == LAST);
    if (done_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d = cnt_q + 1'b1;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign tx_o   = ~busy_q;

  a_r4_tx_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> cnt_q <= LAST);
  a_r4_start_ignored_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !done_o |=> busy_q);
endmodule

// File: rtl/lps_wake_rx.sv
module lps_wake_rx #(
  parameter int MIN = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic en_i,
  output logic detect_o
);
  localparam int CW = $clog2(MIN + 1);
  localparam logic [CW-1:0] TOP  = CW'(MIN);
  localparam logic [CW-1:0] LAST = CW'(MIN - 1);

  logic [CW-1:0] low_q, low_d;

  always_comb begin
    detect_o = 1'b0;
    low_d    = '0;
    if (!rx_i && en_i) begin
      low_d    = (low_q < TOP) ? low_q + 1'b1 : low_q;
      detect_o = (low_q == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= '0;
    else        low_q <= low_d;
  end

  a_r7_one_detect_per_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    detect_o |=> !detect_o);
endmodule

// File: rtl/lin_power_supervisor.sv
module lin_power_supervisor
  import lps_pkg::*;
#(
  parameter int CLK_PER_MS  = 50000,
  parameter int IDLE_MS     = 4000,
  parameter int RESP_MS     = 150,
  parameter int WAKE_TX_CYC = 50000,
  parameter int WAKE_RX_MIN = 7500,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             master_mode_i,
  input  logic             frame_err_i,
  input  logic             lin_rx_i,
  output logic             lin_tx_o,
  output logic             sleep_o,
  output logic [REG_W-1:0] status_o,
  output logic [EC_W-1:0]  err_code_o,
  output logic             irq_o,
  output logic             frame_go_o,
  output logic             frame_abort_o
);
  // reset: asserted at once, released through a synchroniser
  logic [SYNC_STAGES-1:0] rsync_q;
  logic rst_sn;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_rsync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsync_q[gi] <= 1'b0;
        else if (gi == 0) rsync_q[gi] <= 1'b1;
        else rsync_q[gi] <= rsync_q[(gi > 0) ? gi - 1 : 0];
      end
    end
  endgenerate
  assign rst_sn = rsync_q[SYNC_STAGES-1];

  // state
  logic            sleep_q, sleep_d;
  logic            done_q, done_d;
  logic            wake_q, wake_d;
  logic            err_q, err_d;
  logic            idle_q, idle_d;
  logic [EC_W-1:0] ec_q, ec_d;
  logic            resp_q, resp_d;
  logic            go_q, go_d;
  logic            abort_q, abort_d;
  logic            rx_q;

  logic tick, idle_exp, resp_exp, tx_busy, tx_done, rx_wake;
  logic ctrl_wr, stat_wr, wake_start, rx_edge, rx_fall;

  assign ctrl_wr    = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_CTRL);
  assign stat_wr    = wr_en_i && (wr_sel_e'(wr_sel_i) == SEL_STAT);
  assign wake_start = ctrl_wr && wr_data_i[CTL_WAKE] && !err_q && !tx_busy;
  assign rx_edge    = rx_q ^ lin_rx_i;
  assign rx_fall    = rx_q && !lin_rx_i;

  lps_ms_tick #(.CLK_PER_MS(CLK_PER_MS)) u_tick (
    .clk(clk), .rst_n(rst_sn), .tick_o(tick));

  lps_ms_timer #(.LIMIT(IDLE_MS)) u_idle (
    .clk(clk), .rst_n(rst_sn), .tick_i(tick),
    .clear_i(rx_edge || sleep_q), .expire_o(idle_exp));

  lps_ms_timer #(.LIMIT(RESP_MS)) u_resp (
    .clk(clk), .rst_n(rst_sn), .tick_i(tick),
    .clear_i(!resp_q), .expire_o(resp_exp));

  lps_wake_tx #(.LEN(WAKE_TX_CYC)) u_tx (
    .clk(clk), .rst_n(rst_sn), .start_i(wake_start),
    .busy_o(tx_busy), .done_o(tx_done), .tx_o(lin_tx_o));

  lps_wake_rx #(.MIN(WAKE_RX_MIN)) u_rx (
    .clk(clk), .rst_n(rst_sn), .rx_i(lin_rx_i), .en_i(!tx_busy),
    .detect_o(rx_wake));

  // next state
  always_comb begin
    sleep_d = ctrl_wr ? wr_data_i[CTL_SLEEP] : sleep_q;

    done_d = (done_q && !(stat_wr && wr_data_i[ST_DONE]))
           || (tx_done && master_mode_i) || rx_wake;
    wake_d = (wake_q && !(stat_wr && wr_data_i[ST_WAKE])) || rx_wake;
    idle_d = (idle_q && !(stat_wr && wr_data_i[ST_IDLE])) || idle_exp;

    err_d = err_q;
    ec_d  = ec_q;
    if (ctrl_wr && wr_data_i[CTL_RSTERR]) begin
      err_d = 1'b0;
      ec_d  = '0;
    end
    if (resp_exp) begin
      err_d          = 1'b1;
      ec_d[EC_TOUT]  = 1'b1;
    end
    if (frame_err_i) begin
      err_d          = 1'b1;
      ec_d[EC_FRAME] = 1'b1;
    end

    resp_d = resp_q;
    if (tx_done && !master_mode_i)  resp_d = 1'b1;
    else if (rx_fall || resp_exp)   resp_d = 1'b0;

    go_d    = ctrl_wr && wr_data_i[CTL_FRAME] && master_mode_i && !err_q;
    abort_d = frame_err_i;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sleep_q <= 1'b0;
      done_q  <= 1'b0;
      wake_q  <= 1'b0;
      err_q   <= 1'b0;
      idle_q  <= 1'b0;
      ec_q    <= '0;
      resp_q  <= 1'b0;
      go_q    <= 1'b0;
      abort_q <= 1'b0;
      rx_q    <= 1'b1;
    end else begin
      sleep_q <= sleep_d;
      done_q  <= done_d;
      wake_q  <= wake_d;
      err_q   <= err_d;
      idle_q  <= idle_d;
      ec_q    <= ec_d;
      resp_q  <= resp_d;
      go_q    <= go_d;
      abort_q <= abort_d;
      rx_q    <= lin_rx_i;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[ST_DONE] = done_q;
    status_o[ST_WAKE] = wake_q;
    status_o[ST_ERR]  = err_q;
    status_o[ST_IDLE] = idle_q;
  end

  assign sleep_o       = sleep_q;
  assign err_code_o    = ec_q;
  assign irq_o         = |status_o;
  assign frame_go_o    = go_q;
  assign frame_abort_o = abort_q;

  a_r10_no_wake_tx_under_error: assert property (@(posedge clk) disable iff (!rst_sn)
    $fell(lin_tx_o) |-> $past(!err_q));
  a_r10_frame_grant_gated: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_go_o |-> $past(master_mode_i && !err_q));
  a_r2_sleep_only_by_write: assert property (@(posedge clk) disable iff (!rst_sn)
    !ctrl_wr |=> $stable(sleep_o));
  a_r3_no_idle_in_sleep: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(idle_q) |-> $past(!sleep_q));
  a_r6_timeout_only_slave: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(err_code_o[EC_TOUT]) |-> !master_mode_i);
  a_r8_abort_follows_error: assert property (@(posedge clk) disable iff (!rst_sn)
    frame_abort_o |-> err_code_o[EC_FRAME]);
endmodule

// File: tb/lin_power_supervisor_tb.sv
module lin_power_supervisor_tb_top;
  localparam int CPM = 10, IDLE = 8, RESP = 5, TXC = 6, RXM = 4;

  logic clk, rst_n, wr_en, wr_sel, mode, ferr, bus_pull_n;
  logic [3:0] wr_data;
  logic tx, sleep, irq, go, abort;
  logic [3:0] st;
  logic [1:0] ec;
  logic rx;
  int n_run, n_fail;
  bit finished;

  assign rx = tx & bus_pull_n;

  lin_power_supervisor #(.CLK_PER_MS(CPM), .IDLE_MS(IDLE), .RESP_MS(RESP),
    .WAKE_TX_CYC(TXC), .WAKE_RX_MIN(RXM)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .master_mode_i(mode), .frame_err_i(ferr),
    .lin_rx_i(rx), .lin_tx_o(tx), .sleep_o(sleep), .status_o(st),
    .err_code_o(ec), .irq_o(irq), .frame_go_o(go), .frame_abort_o(abort));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pull_low(input int n);
    bus_pull_n = 1'b0;
    idle_cyc(n);
    bus_pull_n = 1'b1;
  endtask

  // returns number of sampled low cycles of tx (counts up to limit)
  task automatic measure_tx(input int limit, output int lowc);
    lowc = 0;
    for (int i = 0; i < limit; i++) begin
      if (tx == 1'b0) lowc++;
      else if (lowc > 0) break;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lowc;
    n_run = 0; n_fail = 0; finished = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
    mode = 1'b1; ferr = 1'b0; bus_pull_n = 1'b1;
    idle_cyc(3);
    rst_n = 1'b1;
    idle_cyc(4);

    // R1 reset state
    chk("R1 tx", tx, 1); chk("R1 sleep", sleep, 0); chk("R1 status", st, 0);
    chk("R1 err_code", ec, 0); chk("R1 irq", irq, 0);
    chk("R1 go", go, 0); chk("R1 abort", abort, 0);

    // R3 idle timeout: short edge pulse then silence
    pull_low(1);
    idle_cyc(60);
    chk("R3 idle not yet", st[3], 0);
    idle_cyc(40);
    chk("R3 idle set", st[3], 1);
    chk("R11 irq from idle", irq, 1);
    wr(1'b1, 4'b1000);
    chk("R11 idle cleared", st[3], 0);

    // R2/R3 sleep holds idle counter
    wr(1'b0, 4'b0001);
    chk("R2 sleep set", sleep, 1);
    pull_low(1);
    idle_cyc(200);
    chk("R3 no idle in sleep", st[3], 0);
    chk("R2 sleep kept", sleep, 1);
    wr(1'b0, 4'b0000);
    chk("R2 sleep cleared", sleep, 0);
    idle_cyc(100);
    chk("R3 idle after sleep", st[3], 1);
    chk("R2 sleep not auto set", sleep, 0);
    wr(1'b1, 4'b1000);

    // R7 wake detection sweep over low lengths
    for (int len = 1; len <= 8; len++) begin
      wr(1'b1, 4'b1011);
      pull_low(len);
      idle_cyc(2);
      chk($sformatf("R7 wakeup len %0d", len), st[1], (len >= RXM) ? 1 : 0);
      chk($sformatf("R7 done len %0d", len), st[0], (len >= RXM) ? 1 : 0);
    end

    // R11 selective clear, bit 2 ignored
    wr(1'b1, 4'b0001);
    chk("R11 done cleared", st[0], 0);
    chk("R11 wakeup kept", st[1], 1);
    wr(1'b1, 4'b0010);
    chk("R11 wakeup cleared", st[1], 0);

    // R4/R5 master wake-up
    mode = 1'b1;
    wr(1'b1, 4'b1011);
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b0010;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    measure_tx(40, lowc);
    chk("R4 master pulse length", lowc, TXC);
    chk("R5 master done", st[0], 1);
    chk("R5 irq", irq, 1);
    chk("R7 own pulse not wakeup", st[1], 0);

    // R6 slave wake-up with no response
    mode = 1'b0;
    wr(1'b1, 4'b1011);
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b0010;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    measure_tx(40, lowc);
    chk("R4 slave pulse length", lowc, TXC);
    chk("R6 slave no done", st[0], 0);
    idle_cyc(30);
    chk("R6 no early timeout", st[2], 0);
    idle_cyc(40);
    chk("R6 timeout error", st[2], 1);
    chk("R6 timeout code", ec, 2'b01);
    chk("R6 slave still no done", st[0], 0);

    // R10 requests blocked by error; R11 bit 2 ignored
    mode = 1'b1;
    wr(1'b1, 4'b0100);
    chk("R11 error not W1C", st[2], 1);
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b1010;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R10 frame blocked", go, 0);
    measure_tx(12, lowc);
    chk("R10 wake blocked", lowc, 0);

    // R9 reset error
    wr(1'b0, 4'b0100);
    chk("R9 error cleared", st[2], 0);
    chk("R9 code cleared", ec, 0);

    // R10 frame grant in master, ignored in slave
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b1000;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R10 frame go pulse", go, 1);
    @(negedge clk);
    chk("R10 frame go one cycle", go, 0);
    mode = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b1000;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    chk("R10 slave frame ignored", go, 0);

    // R6 slave wake-up answered by master
    wr(1'b1, 4'b1011);
    @(negedge clk); wr_en = 1'b1; wr_sel = 1'b0; wr_data = 4'b0010;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
    measure_tx(40, lowc);
    idle_cyc(10);
    pull_low(2);
    idle_cyc(80);
    chk("R6 answered no error", st[2], 0);
    chk("R6 answered code", ec, 0);

    // R8 frame error
    mode = 1'b1;
    @(negedge clk); ferr = 1'b1;
    @(negedge clk); ferr = 1'b0;
    chk("R8 error set", st[2], 1);
    chk("R8 code", ec, 2'b10);
    chk("R8 abort pulse", abort, 1);
    @(negedge clk);
    chk("R8 abort one cycle", abort, 0);
    wr(1'b0, 4'b0100);
    chk("R9 clear after frame error", {st[2], ec}, 3'b000);

    finish_run();
  end
endmodule